// File: doc/BRIEF.md
# Single-Cycle Instruction Decode Control

This block is the purely combinational control unit of a 32-bit single-cycle load/store processor. Each cycle it looks at the 6-bit opcode of the fetched instruction, the zero flag from the branch comparator and an asynchronous interrupt request. From these it drives every select and enable the datapath needs: the ALU function code, register-file write enable, B-operand literal select, write-data source, data-memory write, second-read-port address source, next-PC source, A-operand source and the write-address override. It also raises a flag when the opcode is not implemented. The ALU, memories and register storage sit outside the block.

Decoding runs in three stages. The first sorts the opcode into one of nine classes: register operate (OP), literal operate (OPC), load (LD), store (ST), jump (JMP), branch-if-zero (BEQ), branch-if-nonzero (BNE), PC-relative load (LDR) and illegal (ILL). The second turns the class into a control word. The BEQ and BNE classes make their branch choice on the zero flag. The ILL class becomes a forced call to the illegal-opcode vector. The third stage is the interrupt override. When the interrupt request is high, the control word is replaced by a forced call to the interrupt vector, whatever class was decoded. A forced call does not stop the machine. It writes the return address (PC+4) into register 30 and redirects fetch.

Top module: `scd_decode`

## Requirements
- R1: An opcode 10xxxx whose low nibble is in the enabled function set (default 0,1,4,5,6,8,9,10,12,13,14) drives alu_fn equal to the opcode, rf_we=1, opb_lit=0, wd_src=1 (ALU), pc_src=0 (PC+4). dmem_we, rd2_from_rc, opa_pc, wa_xp and bad_op are all 0.
- R2: An opcode 11xxxx with an enabled low nibble behaves as in R1, except that opb_lit=1.
- R3: An operate opcode (1xxxxx) whose low nibble is 2, 3, 7, 11 or 15 is illegal. This covers the multiply and divide encodings, which are disabled by default.
- R4: Load 011000 drives alu_fn=6'h20 (add), rf_we=1, opb_lit=1, wd_src=2 (memory) and pc_src=0. All other selects are 0.
- R5: Store 011001 drives dmem_we=1, rf_we=0, rd2_from_rc=1, opb_lit=1, alu_fn=6'h20 and pc_src=0. No other opcode ever drives dmem_we.
- R6: Jump 011011 drives rf_we=1, wd_src=0 (PC+4) and pc_src=2 (register target).
- R7: Branch-if-zero 011100 drives rf_we=1 and wd_src=0. It drives pc_src=1 (branch target) when zero=1 and pc_src=0 when zero=0.
- R8: Branch-if-nonzero 011101 works as in R7 with the zero test inverted.
- R9: PC-relative load 011111 drives opa_pc=1, alu_fn=6'h1A (pass A), opb_lit=0, rf_we=1 and wd_src=2.
- R10: Every other opcode sets bad_op=1 and drives a forced call: rf_we=1, wa_xp=1 (write register 30), wd_src=0, pc_src=3, dmem_we=0, alu_fn=0. All other selects are 0.
- R11: When irq=1, the outputs are a forced call with pc_src=4, rf_we=1, wa_xp=1, wd_src=0, and dmem_we, opb_lit, opa_pc, rd2_from_rc and alu_fn all 0. This holds for any opcode. bad_op still reports the opcode's legality.
- R12: wa_xp is 1 exactly when irq=1 or the opcode is illegal, and pc_src is 3 or 4 only in those cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction bits 31:26 |
| zero | input | 1 | Register Ra equals zero (branch test) |
| irq | input | 1 | Asynchronous interrupt request |
| alu_fn | output | 6 | ALU function code |
| rf_we | output | 1 | Register-file write enable |
| opb_lit | output | 1 | B operand from sign-extended literal |
| wd_src | output | 2 | Write data: 0 PC+4, 1 ALU, 2 memory |
| dmem_we | output | 1 | Data-memory write |
| rd2_from_rc | output | 1 | Second read port addresses Rc instead of Rb |
| pc_src | output | 3 | Next PC: 0 PC+4, 1 branch, 2 jump, 3 illegal vector, 4 interrupt vector |
| opa_pc | output | 1 | A operand from branch-target address |
| wa_xp | output | 1 | Write address forced to register 30 |
| bad_op | output | 1 | Opcode not implemented |

## Verification
The interrupt override and the class decode can act in the same cycle. In the overlap the override must win completely. The bench raises irq while presenting a store, a legal operate, a taken branch and an illegal opcode. It requires pc_src=4 and dmem_we=0 in each case, and requires bad_op to keep reporting the opcode's legality. An exhaustive sweep over every opcode, both zero values and both irq values then checks the write-address override and the memory-write exclusivity.

// File: rtl/scd_pkg.sv
package scd_pkg;

    localparam int OP_W   = 6;
    localparam int FN_W   = 4;
    localparam int WD_W   = 2;
    localparam int PC_W   = 3;

    localparam logic [OP_W-1:0] OPC_LD  = 6'b011000;
    localparam logic [OP_W-1:0] OPC_ST  = 6'b011001;
    localparam logic [OP_W-1:0] OPC_JMP = 6'b011011;
    localparam logic [OP_W-1:0] OPC_BEQ = 6'b011100;
    localparam logic [OP_W-1:0] OPC_BNE = 6'b011101;
    localparam logic [OP_W-1:0] OPC_LDR = 6'b011111;

    typedef enum logic [3:0] {
        CLS_OP,
        CLS_OPC,
        CLS_LD,
        CLS_ST,
        CLS_JMP,
        CLS_BEQ,
        CLS_BNE,
        CLS_LDR,
        CLS_ILL
    } op_class_e;

    typedef enum logic [WD_W-1:0] {
        WD_PC4 = 2'd0,
        WD_ALU = 2'd1,
        WD_MEM = 2'd2
    } wd_src_e;

    typedef enum logic [PC_W-1:0] {
        PC_SEQ  = 3'd0,
        PC_BR   = 3'd1,
        PC_JMP  = 3'd2,
        PC_ILL  = 3'd3,
        PC_IRQ  = 3'd4
    } pc_src_e;

    typedef struct packed {
        logic [OP_W-1:0] alu_fn;
        logic            rf_we;
        logic            opb_lit;
        wd_src_e         wd_src;
        logic            dmem_we;
        logic            rd2_from_rc;
        pc_src_e         pc_src;
        logic            opa_pc;
        logic            wa_xp;
    } ctl_t;

    // Forced procedure call: link PC+4 into register 30 and jump to a vector.
    function automatic ctl_t forced_call(pc_src_e vec);
        ctl_t c;
        c             = '0;
        c.rf_we       = 1'b1;
        c.wa_xp       = 1'b1;
        c.wd_src      = WD_PC4;
        c.pc_src      = vec;
        return c;
    endfunction

endpackage

// File: rtl/scd_classify.sv
module scd_classify
    import scd_pkg::*;
#(
    parameter logic [(1<<FN_W)-1:0] FUNC_MASK = 16'h7773
) (
    input  logic [OP_W-1:0] opcode,
    output op_class_e       cls
);

    always_comb begin
        cls = CLS_ILL;
        if (opcode[OP_W-1]) begin
            if (FUNC_MASK[opcode[FN_W-1:0]]) begin
                cls = opcode[OP_W-2] ? CLS_OPC : CLS_OP;
            end
        end else begin
            unique case (opcode)
                OPC_LD:  cls = CLS_LD;
                OPC_ST:  cls = CLS_ST;
                OPC_JMP: cls = CLS_JMP;
                OPC_BEQ: cls = CLS_BEQ;
                OPC_BNE: cls = CLS_BNE;
                OPC_LDR: cls = CLS_LDR;
                default: cls = CLS_ILL;
            endcase
        end
    end

endmodule

// File: rtl/scd_class_ctl.sv
module scd_class_ctl
    import scd_pkg::*;
#(
    parameter logic [OP_W-1:0] ALUFN_ADD   = 6'h20,
    parameter logic [OP_W-1:0] ALUFN_PASSA = 6'h1A
) (
    input  op_class_e       cls,
    input  logic [OP_W-1:0] opcode,
    input  logic            zero,
    output ctl_t            ctl
);

    always_comb begin
        ctl = '0;
        unique case (cls)
            CLS_OP: begin
                ctl.alu_fn = opcode;
                ctl.rf_we  = 1'b1;
                ctl.wd_src = WD_ALU;
            end
            CLS_OPC: begin
                ctl.alu_fn  = opcode;
                ctl.rf_we   = 1'b1;
                ctl.opb_lit = 1'b1;
                ctl.wd_src  = WD_ALU;
            end
            CLS_LD: begin
                ctl.alu_fn  = ALUFN_ADD;
                ctl.rf_we   = 1'b1;
                ctl.opb_lit = 1'b1;
                ctl.wd_src  = WD_MEM;
            end
            CLS_ST: begin
                ctl.alu_fn      = ALUFN_ADD;
                ctl.opb_lit     = 1'b1;
                ctl.dmem_we     = 1'b1;
                ctl.rd2_from_rc = 1'b1;
            end
            CLS_JMP: begin
                ctl.rf_we  = 1'b1;
                ctl.wd_src = WD_PC4;
                ctl.pc_src = PC_JMP;
            end
            CLS_BEQ: begin
                ctl.rf_we  = 1'b1;
                ctl.wd_src = WD_PC4;
                ctl.pc_src = zero ? PC_BR : PC_SEQ;
            end
            CLS_BNE: begin
                ctl.rf_we  = 1'b1;
                ctl.wd_src = WD_PC4;
                ctl.pc_src = zero ? PC_SEQ : PC_BR;
            end
            CLS_LDR: begin
                ctl.alu_fn = ALUFN_PASSA;
                ctl.rf_we  = 1'b1;
                ctl.opa_pc = 1'b1;
                ctl.wd_src = WD_MEM;
            end
            CLS_ILL: ctl = forced_call(PC_ILL);
            default: ctl = forced_call(PC_ILL);
        endcase
    end

endmodule

// File: rtl/scd_irq_override.sv
module scd_irq_override
    import scd_pkg::*;
(
    input  ctl_t base,
    input  logic irq,
    output ctl_t ctl
);

    always_comb begin
        if (irq) ctl = forced_call(PC_IRQ);
        else     ctl = base;
    end

endmodule

// File: rtl/scd_decode.sv
module scd_decode
    import scd_pkg::*;
#(
    parameter logic [(1<<FN_W)-1:0] FUNC_MASK   = 16'h7773,
    parameter logic [OP_W-1:0]      ALUFN_ADD   = 6'h20,
    parameter logic [OP_W-1:0]      ALUFN_PASSA = 6'h1A
) (
    input  logic [OP_W-1:0] opcode,
    input  logic            zero,
    input  logic            irq,
    output logic [OP_W-1:0] alu_fn,
    output logic            rf_we,
    output logic            opb_lit,
    output logic [WD_W-1:0] wd_src,
    output logic            dmem_we,
    output logic            rd2_from_rc,
    output logic [PC_W-1:0] pc_src,
    output logic            opa_pc,
    output logic            wa_xp,
    output logic            bad_op
);

    op_class_e cls;
    ctl_t      base_ctl;
    ctl_t      fin_ctl;

    scd_classify #(
        .FUNC_MASK (FUNC_MASK)
    ) u_classify (
        .opcode (opcode),
        .cls    (cls)
    );

    scd_class_ctl #(
        .ALUFN_ADD   (ALUFN_ADD),
        .ALUFN_PASSA (ALUFN_PASSA)
    ) u_class_ctl (
        .cls    (cls),
        .opcode (opcode),
        .zero   (zero),
        .ctl    (base_ctl)
    );

    scd_irq_override u_override (
        .base (base_ctl),
        .irq  (irq),
        .ctl  (fin_ctl)
    );

    assign alu_fn      = fin_ctl.alu_fn;
    assign rf_we       = fin_ctl.rf_we;
    assign opb_lit     = fin_ctl.opb_lit;
    assign wd_src      = fin_ctl.wd_src;
    assign dmem_we     = fin_ctl.dmem_we;
    assign rd2_from_rc = fin_ctl.rd2_from_rc;
    assign pc_src      = fin_ctl.pc_src;
    assign opa_pc      = fin_ctl.opa_pc;
    assign wa_xp       = fin_ctl.wa_xp;
    assign bad_op      = (cls == CLS_ILL);

endmodule

// File: rtl/scd_decode_chk.sv
module scd_decode_chk
    import scd_pkg::*;
(
    input logic [OP_W-1:0] opcode,
    input logic            zero,
    input logic            irq,
    input logic [OP_W-1:0] alu_fn,
    input logic            rf_we,
    input logic            opb_lit,
    input logic [WD_W-1:0] wd_src,
    input logic            dmem_we,
    input logic            rd2_from_rc,
    input logic [PC_W-1:0] pc_src,
    input logic            opa_pc,
    input logic            wa_xp,
    input logic            bad_op
);

    always_comb begin
        // R5: memory write belongs to an uninterrupted store only
        p_store_only_r5: assert (!dmem_we || (opcode == OPC_ST && !irq))
            else $error("dmem_we outside store");
        p_store_no_rf_r5: assert (!(dmem_we && rf_we))
            else $error("store writes register file");
        p_rc_port_r5: assert (!rd2_from_rc || dmem_we)
            else $error("rd2_from_rc without store");
        // R11: interrupt forces the vector call
        p_irq_vector_r11: assert (!irq || (pc_src == 3'd4 && wa_xp && rf_we
                                   && wd_src == 2'd0 && !opb_lit && !opa_pc
                                   && alu_fn == '0))
            else $error("irq override incomplete");
        // R10: illegal opcode vector
        p_ill_vector_r10: assert (irq || !bad_op || pc_src == 3'd3)
            else $error("illegal opcode not vectored");
        // R12: register-30 write only for forced calls
        p_xp_r12: assert (wa_xp == (irq || bad_op))
            else $error("wa_xp mismatch");
        // R7: branch-if-zero follows the flag
        p_beq_r7: assert (irq || opcode != OPC_BEQ || pc_src == (zero ? 3'd1 : 3'd0))
            else $error("beq pc_src");
        // R9: A operand from PC only for the PC-relative load
        p_opa_r9: assert (!opa_pc || (opcode == OPC_LDR && wd_src == 2'd2))
            else $error("opa_pc outside pc-relative load");
        // R1: operate code passes through
        p_alufn_r1: assert (irq || bad_op || !opcode[OP_W-1] || alu_fn == opcode)
            else $error("alu_fn not opcode");
    end

endmodule

bind scd_decode scd_decode_chk u_chk (
    .opcode      (opcode),
    .zero        (zero),
    .irq         (irq),
    .alu_fn      (alu_fn),
    .rf_we       (rf_we),
    .opb_lit     (opb_lit),
    .wd_src      (wd_src),
    .dmem_we     (dmem_we),
    .rd2_from_rc (rd2_from_rc),
    .pc_src      (pc_src),
    .opa_pc      (opa_pc),
    .wa_xp       (wa_xp),
    .bad_op      (bad_op)
);

// File: tb/scd_decode_tb.sv
module scd_decode_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = '0;
    logic       zero = 1'b0;
    logic       irq = 1'b0;
    logic [5:0] alu_fn;
    logic       rf_we, opb_lit, dmem_we, rd2_from_rc, opa_pc, wa_xp, bad_op;
    logic [1:0] wd_src;
    logic [2:0] pc_src;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    scd_decode u_dut (
        .opcode (opcode), .zero (zero), .irq (irq),
        .alu_fn (alu_fn), .rf_we (rf_we), .opb_lit (opb_lit),
        .wd_src (wd_src), .dmem_we (dmem_we), .rd2_from_rc (rd2_from_rc),
        .pc_src (pc_src), .opa_pc (opa_pc), .wa_xp (wa_xp), .bad_op (bad_op)
    );

    // expected bundle: {alu_fn, rf_we, opb_lit, wd_src, dmem_we, rd2_from_rc, pc_src, opa_pc, wa_xp, bad_op}
    function automatic logic [17:0] ex(logic [5:0] a, logic we, logic bl, logic [1:0] wd,
                                       logic mw, logic r2, logic [2:0] pc, logic aa,
                                       logic wx, logic bo);
        return {a, we, bl, wd, mw, r2, pc, aa, wx, bo};
    endfunction

    function automatic logic [29:0] mk(logic [3:0] r, logic i, logic z, logic [5:0] op,
                                       logic [17:0] e);
        return {r, i, z, op, e};
    endfunction

    function automatic string rq(logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R12";
        endcase
    endfunction

    localparam logic [17:0] T_ILL = 18'({6'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b1, 1'b1});
    localparam logic [17:0] T_IRQ = 18'({6'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0});
    localparam logic [17:0] T_IRQ_BAD = T_IRQ | 18'd1;

    localparam int NV = 23;
    localparam logic [29:0] VEC [NV] = '{
        mk(4'd1,  0, 0, 6'b100000, ex(6'b100000, 1, 0, 2'd1, 0, 0, 3'd0, 0, 0, 0)), // R1 add
        mk(4'd1,  0, 1, 6'b101110, ex(6'b101110, 1, 0, 2'd1, 0, 0, 3'd0, 0, 0, 0)), // R1 sra
        mk(4'd1,  0, 0, 6'b100110, ex(6'b100110, 1, 0, 2'd1, 0, 0, 3'd0, 0, 0, 0)), // R1 cmple
        mk(4'd2,  0, 0, 6'b110000, ex(6'b110000, 1, 1, 2'd1, 0, 0, 3'd0, 0, 0, 0)), // R2 addc
        mk(4'd2,  0, 1, 6'b111010, ex(6'b111010, 1, 1, 2'd1, 0, 0, 3'd0, 0, 0, 0)), // R2 xorc
        mk(4'd3,  0, 0, 6'b100010, T_ILL),                                          // R3 mul
        mk(4'd3,  0, 0, 6'b110011, T_ILL),                                          // R3 divc
        mk(4'd3,  0, 1, 6'b101111, T_ILL),                                          // R3 reserved
        mk(4'd4,  0, 0, 6'b011000, ex(6'h20, 1, 1, 2'd2, 0, 0, 3'd0, 0, 0, 0)),     // R4 load
        mk(4'd5,  0, 0, 6'b011001, ex(6'h20, 0, 1, 2'd0, 1, 1, 3'd0, 0, 0, 0)),     // R5 store
        mk(4'd6,  0, 1, 6'b011011, ex(6'h00, 1, 0, 2'd0, 0, 0, 3'd2, 0, 0, 0)),     // R6 jump
        mk(4'd7,  0, 1, 6'b011100, ex(6'h00, 1, 0, 2'd0, 0, 0, 3'd1, 0, 0, 0)),     // R7 taken
        mk(4'd7,  0, 0, 6'b011100, ex(6'h00, 1, 0, 2'd0, 0, 0, 3'd0, 0, 0, 0)),     // R7 not taken
        mk(4'd8,  0, 0, 6'b011101, ex(6'h00, 1, 0, 2'd0, 0, 0, 3'd1, 0, 0, 0)),     // R8 taken
        mk(4'd8,  0, 1, 6'b011101, ex(6'h00, 1, 0, 2'd0, 0, 0, 3'd0, 0, 0, 0)),     // R8 not taken
        mk(4'd9,  0, 0, 6'b011111, ex(6'h1A, 1, 0, 2'd2, 0, 0, 3'd0, 1, 0, 0)),     // R9 pc-rel load
        mk(4'd10, 0, 0, 6'b000000, T_ILL),                                          // R10
        mk(4'd10, 0, 1, 6'b011010, T_ILL),                                          // R10 gap
        mk(4'd10, 0, 0, 6'b011110, T_ILL),                                          // R10 gap
        mk(4'd11, 1, 0, 6'b011001, T_IRQ),                                          // R11 over store
        mk(4'd11, 1, 0, 6'b100000, T_IRQ),                                          // R11 over add
        mk(4'd11, 1, 0, 6'b000111, T_IRQ_BAD),                                      // R11 over illegal
        mk(4'd11, 1, 1, 6'b011100, T_IRQ)                                           // R11 over taken beq
    };

    function automatic logic [17:0] obs();
        return {alu_fn, rf_we, opb_lit, wd_src, dmem_we, rd2_from_rc, pc_src, opa_pc, wa_xp, bad_op};
    endfunction

    task automatic check(string req, logic [17:0] act, logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    function automatic bit legal(logic [5:0] op);
        if (op[5]) return !(op[3:0] inside {4'd2, 4'd3, 4'd7, 4'd11, 4'd15});
        return op inside {6'b011000, 6'b011001, 6'b011011, 6'b011100, 6'b011101, 6'b011111};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R10 reset state", obs(), T_ILL);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {irq, zero, opcode} = VEC[i][25:18];
            #1;
            check(rq(VEC[i][29:26]), obs(), VEC[i][17:0]);
        end

        // exhaustive sweep of opcode, zero and irq
        for (int o = 0; o < 64; o++) begin
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                opcode = 6'(o);
                zero   = s[0];
                irq    = s[1];
                #1;
                check("R12 wa_xp", 18'(wa_xp), 18'(irq || !legal(opcode)));
                check("R10 bad_op", 18'(bad_op), 18'(!legal(opcode)));
                check("R5 dmem_we", 18'(dmem_we), 18'(opcode == 6'b011001 && !irq));
                check("R12 pc_src vector", 18'(pc_src >= 3'd3), 18'(irq || !legal(opcode)));
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule